// File: doc/BRIEF.md
# Signed-Digit SRT Radix-2 Divider

This block divides one normalised fraction by another, one quotient digit per iteration. Operands arrive as a sign bit plus a magnitude whose top bit is set, so each magnitude lies in [1/2, 1). The quotient sign is fixed from the two operand signs when the operation is accepted, and the rest of the work uses the magnitudes only. The partial remainder is held in redundant signed-digit form, with digits -1, 0 and +1. It starts equal to the dividend magnitude. Quotient digits come out in the same redundant form.

In every iteration four carry-free adders, each taking one signed-digit operand and one plain binary operand, form W+1/2, 1/2-W, W+D and D-W. The signs of the first two choose the quotient digit. The chosen update term, or W itself, is then doubled to give the next remainder. The divisor and the constant 1/2 stay on the binary side of the adders for the whole division. After F iterations the result is presented as a row of signed digits with a separate sign. Converting the quotient to plain binary and adjusting the exponent are left to surrounding logic.

Top module: `srt_sd_divider`

## Requirements
- R1: While reset is asserted and right after it, busy and done are low, quoSign is 0 and every bit of quoPos and quoNeg is 0.
- R2: quoSign equals numSign XOR denSign as sampled on the accepting edge. The quotient digits depend only on the magnitudes.
- R3: A start seen while idle is accepted on that clock edge. busy is then high until done rises exactly 2F+2 clock edges later, where F is iterCount sampled at acceptance. At that same edge busy falls. done is high for exactly one cycle.
- R4: A start asserted while busy is ignored: the running division keeps its operands, its iteration count, its timing and its result.
- R5: Digit k (k = 1..F) sits at index F-k of quoPos/quoNeg and is encoded as +1 = (pos 1, neg 0), -1 = (pos 0, neg 1), 0 = (0, 0). With W0 equal to the dividend magnitude, the digit is -1 when W <= -1/2 (next W = 2(W+D)), +1 when W >= 1/2 (next W = 2(W-D)), and 0 otherwise (next W = 2W).
- R6: With N and D the magnitudes read as integers scaled by 2^FRAC_W, and Qint = sum over i of (quoPos[i] - quoNeg[i])·2^i, the value |2^F·N - 2·D·Qint| is below 2^FRAC_W.
- R7: Exactly F digits are produced. All digit positions at index F and above read as 0 when done is high.
- R8: No digit position ever has both its quoPos and quoNeg bit set.
- R9: While the block is idle and start is low, quoSign, quoPos and quoNeg keep their values.
- R10: The first quotient digit (index F-1) is always +1, because the remainder starts at the dividend, which is at least 1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only while idle |
| numSign | input | 1 | Dividend sign (1 = negative) |
| numMag | input | FRAC_W | Dividend magnitude, MSB set, weight of bit i is 2^(i-FRAC_W) |
| denSign | input | 1 | Divisor sign (1 = negative) |
| denMag | input | FRAC_W | Divisor magnitude, MSB set, same weighting |
| iterCount | input | CNT_W | Number of quotient digits F, 1 to MAX_ITER |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quoSign | output | 1 | Quotient sign |
| quoPos | output | MAX_ITER | Quotient digits equal to +1 |
| quoNeg | output | MAX_ITER | Quotient digits equal to -1 |

## Verification
Counted from the edge that accepts start, busy is due one edge later. done, the sign and the full digit row are all due on edge 2F+2. The bench drives inputs and samples outputs on falling edges. It counts the falling edges from the one where start was driven, requires done to show on falling edge 2F+3, and reads the sign and digits in that same slot. The ignored-start and hold checks re-read the outputs at known falling edges after the extra stimulus, so a result that moves early or late is caught.

// File: rtl/srt_sd_pkg.sv
package srt_sd_pkg;

  // Strobes from the sequencer to the datapath, one per activity
  typedef struct packed {
    logic loadOps;    // capture operands and sign
    logic loadRem;    // remainder <= dividend, clear quotient
    logic calcTerms;  // register the four adder outputs
    logic stepDigit;  // select digit, update remainder
  } srtStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_CALC,
    ST_STEP,
    ST_FIN
  } srtState_t;

endpackage

// File: rtl/srt_sd_mbadd.sv
// Carry-free add of a signed-digit vector and a plain binary vector.
// Digit i: s = m + b in {-1..2}; transfer t = (s >= 1), interim u = s - 2t
// (u in {-1,0}); result digit i = u[i] + t[i-1], always in {-1,0,1}.
module srt_sd_mbadd #(
  parameter int DIGITS = 10
) (
  input  logic [DIGITS-1:0] mPos,
  input  logic [DIGITS-1:0] mNeg,
  input  logic [DIGITS-1:0] bBits,
  output logic [DIGITS:0]   sPos,
  output logic [DIGITS:0]   sNeg
);

  logic [DIGITS-1:0] xfer;
  logic [DIGITS-1:0] interim;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign xfer[i]    = mPos[i] | (bBits[i] & ~mNeg[i]);
    assign interim[i] = (mPos[i] & ~bBits[i]) | (mNeg[i] & ~bBits[i]) |
                        (~mPos[i] & ~mNeg[i] & bBits[i]);
    if (i == 0) begin : g_lsb
      assign sPos[i] = 1'b0;
      assign sNeg[i] = interim[i];
    end else begin : g_mid
      assign sPos[i] = xfer[i-1] & ~interim[i];
      assign sNeg[i] = interim[i] & ~xfer[i-1];
    end
  end

  assign sPos[DIGITS] = xfer[DIGITS-1];
  assign sNeg[DIGITS] = 1'b0;

endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
  import srt_sd_pkg::*;
#(
  parameter int FRAC_W   = 8,
  parameter int MAX_ITER = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  srtStrobe_t          strobe,
  input  logic                numSign,
  input  logic [FRAC_W-1:0]   numMag,
  input  logic                denSign,
  input  logic [FRAC_W-1:0]   denMag,
  output logic                quoSign,
  output logic [MAX_ITER-1:0] quoPos,
  output logic [MAX_ITER-1:0] quoNeg
);

  localparam int RW = FRAC_W + 2;   // remainder digits: weights 2, 1, fraction
  localparam int TW = RW + 1;       // adder output digits
  localparam int LW = TW + 1;       // doubled update digits
  localparam logic [RW-1:0] HALF_BITS = {{(RW-1){1'b0}}, 1'b1} << (FRAC_W - 1);
  localparam logic [LW-1:0] UPPER_MASK = ~(({{(LW-1){1'b0}}, 1'b1} << FRAC_W) -
                                           {{(LW-1){1'b0}}, 1'b1});

  // Sign of the leading nonzero digit: 2'b01 positive, 2'b10 negative, 2'b00 zero
  function automatic logic [1:0] leadSign(input logic [LW-1:0] p, input logic [LW-1:0] n);
    logic [1:0] res;
    logic found;
    res = 2'b00;
    found = 1'b0;
    for (int i = LW - 1; i >= 0; i--) begin
      if (!found && (p[i] | n[i])) begin
        found = 1'b1;
        res = {n[i], p[i]};
      end
    end
    return res;
  endfunction

  logic [FRAC_W-1:0] numReg, denReg;
  logic              signReg;
  logic [RW-1:0]     remPos, remNeg;
  logic [TW-1:0]     sumPos [4];
  logic [TW-1:0]     sumNeg [4];
  logic [TW-1:0]     termPos [4];
  logic [TW-1:0]     termNeg [4];
  logic [MAX_ITER-1:0] quoPosR, quoNegR;

  // Terms: 0 = W + 1/2, 1 = 1/2 - W, 2 = W + D, 3 = D - W
  for (genvar t = 0; t < 4; t++) begin : g_term
    logic [RW-1:0] opPos, opNeg, opBin;
    if (t % 2 == 1) begin : g_negW
      assign opPos = remNeg;
      assign opNeg = remPos;
    end else begin : g_posW
      assign opPos = remPos;
      assign opNeg = remNeg;
    end
    if (t < 2) begin : g_half
      assign opBin = HALF_BITS;
    end else begin : g_den
      assign opBin = {2'b00, denReg};
    end
    srt_sd_mbadd #(.DIGITS(RW)) u_add (
      .mPos (opPos),
      .mNeg (opNeg),
      .bBits(opBin),
      .sPos (sumPos[t]),
      .sNeg (sumNeg[t])
    );
  end

  logic [1:0]    leadHi, leadLo, foldSign;
  logic          qPos, qNeg;
  logic [TW-1:0] updPos, updNeg;
  logic [LW-1:0] dblPos, dblNeg;
  logic [RW-1:0] nextPos, nextNeg;

  always_comb begin
    leadHi = leadSign({1'b0, termPos[0]}, {1'b0, termNeg[0]});
    leadLo = leadSign({1'b0, termPos[1]}, {1'b0, termNeg[1]});
    if (leadHi != 2'b01) begin
      qPos = 1'b0; qNeg = 1'b1;
      updPos = termPos[2]; updNeg = termNeg[2];
    end else if (leadLo != 2'b01) begin
      qPos = 1'b1; qNeg = 1'b0;
      updPos = termNeg[3]; updNeg = termPos[3];   // negate D - W
    end else begin
      qPos = 1'b0; qNeg = 1'b0;
      updPos = {1'b0, remPos}; updNeg = {1'b0, remNeg};
    end
    dblPos = {updPos, 1'b0};
    dblNeg = {updNeg, 1'b0};
    // |next W| < 1: all integer digits collapse into the weight-1 digit
    foldSign = leadSign(dblPos & UPPER_MASK, dblNeg & UPPER_MASK);
    nextPos = {1'b0, foldSign[0], dblPos[FRAC_W-1:0]};
    nextNeg = {1'b0, foldSign[1], dblNeg[FRAC_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numReg  <= '0;
      denReg  <= '0;
      signReg <= 1'b0;
      remPos  <= '0;
      remNeg  <= '0;
      quoPosR <= '0;
      quoNegR <= '0;
      for (int t = 0; t < 4; t++) begin
        termPos[t] <= '0;
        termNeg[t] <= '0;
      end
    end else begin
      if (strobe.loadOps) begin
        numReg  <= numMag;
        denReg  <= denMag;
        signReg <= numSign ^ denSign;
      end
      if (strobe.loadRem) begin
        remPos  <= {2'b00, numReg};
        remNeg  <= '0;
        quoPosR <= '0;
        quoNegR <= '0;
      end
      if (strobe.calcTerms) begin
        for (int t = 0; t < 4; t++) begin
          termPos[t] <= sumPos[t];
          termNeg[t] <= sumNeg[t];
        end
      end
      if (strobe.stepDigit) begin
        remPos  <= nextPos;
        remNeg  <= nextNeg;
        quoPosR <= {quoPosR[MAX_ITER-2:0], qPos};
        quoNegR <= {quoNegR[MAX_ITER-2:0], qNeg};
      end
    end
  end

  assign quoSign = signReg;
  assign quoPos  = quoPosR;
  assign quoNeg  = quoNegR;

endmodule

// File: rtl/srt_control.sv
module srt_control
  import srt_sd_pkg::*;
#(
  parameter int MAX_ITER = 12,
  localparam int CNT_W = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] iterCount,
  output srtStrobe_t       strobe,
  output logic             busy,
  output logic             done
);

  srtState_t        state;
  logic [CNT_W-1:0] iterReg, cnt, cntNext;

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterReg <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          iterReg <= iterCount;
          state   <= ST_PREP;
        end
        ST_PREP: begin
          cnt   <= '0;
          state <= ST_CALC;
        end
        ST_CALC: state <= ST_STEP;
        ST_STEP: begin
          cnt   <= cntNext;
          state <= (cntNext == iterReg) ? ST_FIN : ST_CALC;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadOps   = (state == ST_IDLE) && start;
    strobe.loadRem   = (state == ST_PREP);
    strobe.calcTerms = (state == ST_CALC);
    strobe.stepDigit = (state == ST_STEP);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/srt_sd_divider.sv
module srt_sd_divider
  import srt_sd_pkg::*;
#(
  parameter int FRAC_W   = 8,
  parameter int MAX_ITER = 12,
  localparam int CNT_W   = $clog2(MAX_ITER + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                numSign,
  input  logic [FRAC_W-1:0]   numMag,
  input  logic                denSign,
  input  logic [FRAC_W-1:0]   denMag,
  input  logic [CNT_W-1:0]    iterCount,
  output logic                busy,
  output logic                done,
  output logic                quoSign,
  output logic [MAX_ITER-1:0] quoPos,
  output logic [MAX_ITER-1:0] quoNeg
);

  srtStrobe_t strobe;

  srt_control #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .iterCount(iterCount),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  srt_datapath #(.FRAC_W(FRAC_W), .MAX_ITER(MAX_ITER)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .numSign (numSign),
    .numMag  (numMag),
    .denSign (denSign),
    .denMag  (denMag),
    .quoSign (quoSign),
    .quoPos  (quoPos),
    .quoNeg  (quoNeg)
  );

endmodule

// File: rtl/srt_sd_divider_chk.sv
module srt_sd_divider_chk #(
  parameter int FRAC_W   = 8,
  parameter int MAX_ITER = 12,
  localparam int CNT_W   = $clog2(MAX_ITER + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                numSign,
  input logic [FRAC_W-1:0]   numMag,
  input logic                denSign,
  input logic [FRAC_W-1:0]   denMag,
  input logic [CNT_W-1:0]    iterCount,
  input logic                busy,
  input logic                done,
  input logic                quoSign,
  input logic [MAX_ITER-1:0] quoPos,
  input logic [MAX_ITER-1:0] quoNeg
);

  logic             armed;
  logic [CNT_W-1:0] fCap;
  logic             signCap;
  int unsigned      cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      fCap    <= '0;
      signCap <= 1'b0;
      cycCnt  <= 0;
    end else begin
      armed <= 1'b1;
      if (start && !busy) begin
        fCap    <= iterCount;
        signCap <= numSign ^ denSign;
        cycCnt  <= 0;
      end else if (busy) begin
        cycCnt <= cycCnt + 1;
      end
    end
  end

  p_sign_fixed_r2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    done |-> quoSign == signCap);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    done |-> cycCnt == 2 * int'(fCap) + 2);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    done |=> !done);

  p_busy_release_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $fell(busy) |-> done);

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (busy && start) |=> (busy || done));

  p_digit_count_r7: assert property (@(posedge clk) disable iff (!rstN || !armed)
    done |-> ((quoPos | quoNeg) >> fCap) == '0);

  p_digit_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (quoPos & quoNeg) == '0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!busy && !start) |=> ($stable(quoPos) && $stable(quoNeg) && $stable(quoSign)));

  p_first_digit_r10: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (done && fCap != '0) |-> quoPos[fCap - 1'b1]);

endmodule

bind srt_sd_divider srt_sd_divider_chk #(.FRAC_W(FRAC_W), .MAX_ITER(MAX_ITER)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .numSign  (numSign),
  .numMag   (numMag),
  .denSign  (denSign),
  .denMag   (denMag),
  .iterCount(iterCount),
  .busy     (busy),
  .done     (done),
  .quoSign  (quoSign),
  .quoPos   (quoPos),
  .quoNeg   (quoNeg)
);

// File: tb/srt_sd_divider_test.sv
`timescale 1ns/1ps
module srt_sd_divider_test;

  localparam int FRAC_W   = 8;
  localparam int MAX_ITER = 12;
  localparam int CNT_W    = $clog2(MAX_ITER + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic numSign = 1'b0, denSign = 1'b0;
  logic [FRAC_W-1:0] numMag = '0, denMag = '0;
  logic [CNT_W-1:0]  iterCount = '0;
  logic busy, done, quoSign;
  logic [MAX_ITER-1:0] quoPos, quoNeg;

  always #10 clk = ~clk;   // 50 MHz

  srt_sd_divider #(.FRAC_W(FRAC_W), .MAX_ITER(MAX_ITER)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .numSign(numSign), .numMag(numMag), .denSign(denSign), .denMag(denMag),
    .iterCount(iterCount), .busy(busy), .done(done), .quoSign(quoSign),
    .quoPos(quoPos), .quoNeg(quoNeg)
  );

  typedef struct packed {
    logic       ns;
    logic [7:0] n;
    logic       ds;
    logic [7:0] d;
    logic [3:0] f;
    logic       es;   // expected quotient sign
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h80, 1'b0, 8'h80, 4'd8,  1'b0},
    '{1'b1, 8'hC0, 1'b0, 8'h80, 4'd10, 1'b1},
    '{1'b0, 8'hFF, 1'b1, 8'h80, 4'd12, 1'b1},
    '{1'b1, 8'h80, 1'b1, 8'hFF, 4'd6,  1'b0},
    '{1'b0, 8'hAB, 1'b0, 8'hCD, 4'd12, 1'b0},
    '{1'b1, 8'h9A, 1'b1, 8'hE3, 4'd1,  1'b0},
    '{1'b0, 8'hF0, 1'b1, 8'h91, 4'd12, 1'b1},
    '{1'b0, 8'h85, 1'b0, 8'hFB, 4'd7,  1'b0}
  };

  int nChk = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected digits from the selection rule, values scaled by 2^FRAC_W
  function automatic void refDiv(input int n, input int d, input int f,
                                 output logic [MAX_ITER-1:0] eP,
                                 output logic [MAX_ITER-1:0] eN);
    int w;
    int half;
    w = n;
    half = 1 << (FRAC_W - 1);
    eP = '0;
    eN = '0;
    for (int k = 1; k <= f; k++) begin
      if (w <= -half) begin
        eN[f-k] = 1'b1;
        w = 2 * (w + d);
      end else if (w >= half) begin
        eP[f-k] = 1'b1;
        w = 2 * (w - d);
      end else begin
        w = 2 * w;
      end
    end
  endfunction

  task automatic startOp(input logic ns, input logic [7:0] n, input logic ds,
                         input logic [7:0] d, input int f);
    @(negedge clk);
    numSign = ns; numMag = n; denSign = ds; denMag = d;
    iterCount = CNT_W'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // cyc starts at 1 (first falling edge after the start slot)
  task automatic waitDone(inout int cyc);
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic checkResult(input string tag, input logic [7:0] n, input logic [7:0] d,
                             input int f, input logic es);
    logic [MAX_ITER-1:0] eP, eN;
    longint qInt, err;
    refDiv(int'(n), int'(d), f, eP, eN);
    check(quoSign == es, "R2", {tag, " sign"}, quoSign, es);
    check(quoPos == eP, "R5", {tag, " +1 digits"}, quoPos, eP);
    check(quoNeg == eN, "R5", {tag, " -1 digits"}, quoNeg, eN);
    check(((quoPos | quoNeg) >> f) == '0, "R7", {tag, " digits above F"},
          (quoPos | quoNeg) >> f, 0);
    check(quoPos[f-1] == 1'b1, "R10", {tag, " first digit"}, quoPos[f-1], 1);
    qInt = 0;
    for (int i = 0; i < MAX_ITER; i++)
      qInt += (longint'(quoPos[i]) - longint'(quoNeg[i])) <<< i;
    err = (longint'(n) <<< f) - 2 * longint'(d) * qInt;
    if (err < 0) err = -err;
    check(err < (1 << FRAC_W), "R6", {tag, " residual bound"}, err, 1 << FRAC_W);
  endtask

  initial begin : wdog
    #4000000;
    nFail++;
    $display("FAIL R3 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [7:0] holdPos;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    check(quoPos == '0 && quoNeg == '0 && quoSign == 1'b0, "R1", "outputs in reset",
          {quoSign, quoPos, quoNeg}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && quoPos == '0, "R1", "after release", {busy, quoPos}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      startOp(VECS[v].ns, VECS[v].n, VECS[v].ds, VECS[v].d, int'(VECS[v].f));
      check(busy == 1'b1, "R3", "busy after accept", busy, 1);
      cyc = 1;
      waitDone(cyc);
      check(cyc - 1 == 2 * int'(VECS[v].f) + 2, "R3", "done latency", cyc - 1,
            2 * int'(VECS[v].f) + 2);
      check(busy == 1'b0, "R3", "busy low with done", busy, 0);
      checkResult("table", VECS[v].n, VECS[v].d, int'(VECS[v].f), VECS[v].es);
      @(negedge clk);
      check(done == 1'b0, "R3", "done one cycle", done, 0);
    end

    // R9: idle with changing inputs, start low
    holdPos = quoPos[7:0];
    numMag = 8'hC3; denMag = 8'h81; numSign = 1'b1; iterCount = CNT_W'(3);
    repeat (5) @(negedge clk);
    check(quoPos[7:0] == holdPos && busy == 1'b0, "R9", "idle hold", quoPos[7:0], holdPos);

    // R4: second start while busy is ignored
    startOp(1'b0, 8'hAB, 1'b1, 8'h9D, 9);
    cyc = 1;
    @(negedge clk); cyc++;
    numSign = 1'b0; denSign = 1'b0; numMag = 8'h80; denMag = 8'hFF;
    iterCount = CNT_W'(2);
    start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    waitDone(cyc);
    check(cyc - 1 == 20, "R4", "latency with stray start", cyc - 1, 20);
    checkResult("stray-start", 8'hAB, 8'h9D, 9, 1'b1);

    // R5 boundary: max quotient, minimum divisor, full digit count
    startOp(1'b1, 8'hFF, 1'b1, 8'h80, MAX_ITER);
    cyc = 1;
    waitDone(cyc);
    check(cyc - 1 == 2 * MAX_ITER + 2, "R3", "max count latency", cyc - 1, 2 * MAX_ITER + 2);
    checkResult("max", 8'hFF, 8'h80, MAX_ITER, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule